// File: doc/BRIEF.md
# Dual Alias Table Register Renamer

This block maps a small set of architectural registers onto a larger unified physical register file. It keeps two alias tables. The speculative table is read and written at rename time. The committed table changes only when operations retire. A retirement moves a pointer in the committed table and copies no register value, so there is no separate architectural value store. Registers are handed out from a bitmap free pool. A register comes back to the pool when a newer retired mapping for the same architectural register replaces it.

Each cycle the block takes a group of rename requests and a group of retirement notices. Each rename request carries a valid bit, two source registers and an optional destination. Each retirement notice carries the architectural destination and the physical register that now holds it. The rename outputs are combinational in the request cycle: physical source tags, the newly allocated destination tag, and the tag the destination mapped to before. A stall output reports when the group cannot be taken. A flush input throws away all speculative state in one cycle. It copies the committed table over the speculative one and rebuilds the free pool from the committed table.

Top module: `dual_rat_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both tables, and physical registers 8 to 127 are free.
- R2: Each physical source tag is the speculative mapping of its architectural source. A source in a later slot that names the destination of an earlier valid slot in the same group gets that earlier slot's new tag. A slot's own destination does not affect its own sources.
- R3: Each valid slot with a destination gets a distinct free physical register. The lowest-numbered free registers go out first, in slot order (slot 0 before slot 1). The slot's old-tag output shows the mapping it replaces. Slots that are invalid or have no destination take no register and output 0 for both the new tag and the old tag.
- R4: When several slots in one rename group write the same architectural register, the youngest slot's mapping is the one kept in the speculative table.
- R5: The stall output is high when the group asks for more destinations than there are free registers. A stalled group changes neither the speculative table nor the free pool. A group with no destinations never stalls.
- R6: Up to 3 retirement notices per cycle update the committed table. Each notice returns the physical register that the committed table held for that architectural register to the free pool.
- R7: Notices in one retirement group apply in slot order. For a repeated architectural register the youngest notice wins, and every mapping it replaces, including one written earlier in the same group, is freed.
- R8: On flush, the speculative table becomes the committed table, including retirements in the same cycle. The free pool becomes every physical register the committed table does not reference. The stall output is high and the rename group of that cycle is dropped.
- R9: A register freed by retirement can be allocated from the next cycle on, but not in the cycle of its retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard speculative state and restore from the committed table |
| ren_valid_i | input | 2 | Per-slot rename request valid |
| ren_src1_i | input | 2x3 | Per-slot first architectural source |
| ren_src2_i | input | 2x3 | Per-slot second architectural source |
| ren_has_dst_i | input | 2 | Per-slot destination present |
| ren_dst_i | input | 2x3 | Per-slot architectural destination |
| ret_valid_i | input | 3 | Per-slot retirement notice valid |
| ret_arch_i | input | 3x3 | Retiring architectural destination |
| ret_phys_i | input | 3x7 | Physical register holding the retired value |
| ren_stall_o | output | 1 | Rename group not accepted this cycle |
| ren_psrc1_o | output | 2x7 | Per-slot physical tag of source 1 |
| ren_psrc2_o | output | 2x7 | Per-slot physical tag of source 2 |
| ren_pdst_o | output | 2x7 | Per-slot newly allocated physical destination |
| ren_pold_o | output | 2x7 | Per-slot previous mapping of the destination |

## Verification
Rename is driven with groups that cover these cases: independent slots, a later slot reading an earlier slot's destination, both slots writing one register, an invalid slot in front of a valid one, and a slot without a destination in front of one with a destination. Each case separates correct bypass and allocation order from a table lookup that ignores order within the group. Retirement groups repeat an architectural register, and the freed tags then reappear in allocation order, so the bench can tell whether intermediate mappings were returned. The pool is then drained to zero and one register. This checks that stall depends on how many destinations a group asks for and not on slot validity alone. A flush that lands on the same cycle as a retirement shows whether the restore includes that retirement.

// File: rtl/renamer_pkg.sv
package renamer_pkg;

    localparam int ARCH_REGS = 8;
    localparam int PHYS_REGS = 128;
    localparam int REN_WIDTH = 2;
    localparam int RET_WIDTH = 3;

    localparam int ARCH_BITS = $clog2(ARCH_REGS);
    localparam int PHYS_BITS = $clog2(PHYS_REGS);

    typedef logic [ARCH_BITS-1:0] arch_t;
    typedef logic [PHYS_BITS-1:0] phys_t;
    typedef logic [PHYS_REGS-1:0] pmask_t;

    typedef struct packed {
        logic  valid;
        arch_t src1;
        arch_t src2;
        logic  has_dst;
        arch_t dst;
    } ren_req_t;

    typedef struct packed {
        phys_t psrc1;
        phys_t psrc2;
        phys_t pdst;
        phys_t pold;
    } ren_rsp_t;

    typedef struct packed {
        logic  valid;
        arch_t arch;
        phys_t phys;
    } ret_upd_t;

    // Identity mapping used by both tables when reset.
    function automatic phys_t home_tag(int idx);
        return phys_t'(idx);
    endfunction

    function automatic pmask_t tag_bit(phys_t p);
        pmask_t m;
        m    = '0;
        m[p] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rat_front.sv
module rat_front
    import renamer_pkg::*;
#(
    parameter int REN_W = REN_WIDTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     accept,
    input  ren_req_t req     [REN_W],
    input  phys_t    alloc   [REN_W],
    input  phys_t    restore [ARCH_REGS],
    output ren_rsp_t rsp     [REN_W],
    output phys_t    tbl     [ARCH_REGS]
);

    phys_t tbl_q [ARCH_REGS];
    phys_t work  [ARCH_REGS];

    // Slots are walked oldest first so that sources see earlier
    // destinations of the same group and the youngest write wins.
    always_comb begin
        work = tbl_q;
        for (int s = 0; s < REN_W; s++) begin
            rsp[s]       = '0;
            rsp[s].psrc1 = work[req[s].src1];
            rsp[s].psrc2 = work[req[s].src2];
            if (req[s].valid && req[s].has_dst) begin
                rsp[s].pdst        = alloc[s];
                rsp[s].pold        = work[req[s].dst];
                work[req[s].dst]   = alloc[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) tbl_q[i] <= home_tag(i);
        end else if (flush) begin
            tbl_q <= restore;
        end else if (accept) begin
            tbl_q <= work;
        end
    end

    assign tbl = tbl_q;

endmodule

// File: rtl/rat_retire.sv
module rat_retire
    import renamer_pkg::*;
#(
    parameter int RET_W = RET_WIDTH
) (
    input  logic     clk,
    input  logic     rst,
    input  ret_upd_t upd      [RET_W],
    output phys_t    tbl_next [ARCH_REGS],
    output pmask_t   freed,
    output pmask_t   refd
);

    phys_t tbl_q [ARCH_REGS];
    phys_t work  [ARCH_REGS];

    // Notices apply in slot order; every displaced tag is released,
    // including one written by an older notice of the same group.
    always_comb begin
        work  = tbl_q;
        freed = '0;
        for (int r = 0; r < RET_W; r++) begin
            if (upd[r].valid) begin
                freed             = freed | tag_bit(work[upd[r].arch]);
                work[upd[r].arch] = upd[r].phys;
            end
        end
        refd = '0;
        for (int a = 0; a < ARCH_REGS; a++) refd = refd | tag_bit(work[a]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) tbl_q[i] <= home_tag(i);
        end else begin
            tbl_q <= work;
        end
    end

    assign tbl_next = work;

endmodule

// File: rtl/free_pool.sv
module free_pool
    import renamer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  pmask_t take,
    input  pmask_t give,
    input  pmask_t keep,
    output pmask_t avail
);

    pmask_t free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p >= ARCH_REGS);
        end else if (flush) begin
            free_q <= ~keep;
        end else begin
            free_q <= (free_q & ~take) | give;
        end
    end

    assign avail = free_q;

endmodule

// File: rtl/free_picker.sv
module free_picker
    import renamer_pkg::*;
#(
    parameter int REN_W = REN_WIDTH
) (
    input  pmask_t           avail,
    output phys_t            pick    [REN_W],
    output logic [REN_W-1:0] pick_ok
);

    pmask_t stage [REN_W+1];

    assign stage[0] = avail;

    // One lowest-set-bit search per slot, each masking out the previous pick.
    for (genvar k = 0; k < REN_W; k++) begin : g_pick
        always_comb begin
            pick[k]    = '0;
            pick_ok[k] = 1'b0;
            for (int p = PHYS_REGS - 1; p >= 0; p--) begin
                if (stage[k][p]) begin
                    pick[k]    = phys_t'(p);
                    pick_ok[k] = 1'b1;
                end
            end
            stage[k+1] = pick_ok[k] ? (stage[k] & ~tag_bit(pick[k])) : stage[k];
        end
    end

endmodule

// File: rtl/dual_rat_renamer.sv
module dual_rat_renamer
    import renamer_pkg::*;
#(
    parameter int REN_W = REN_WIDTH,
    parameter int RET_W = RET_WIDTH
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             flush_i,
    input  logic [REN_W-1:0]                 ren_valid_i,
    input  logic [REN_W-1:0][ARCH_BITS-1:0]  ren_src1_i,
    input  logic [REN_W-1:0][ARCH_BITS-1:0]  ren_src2_i,
    input  logic [REN_W-1:0]                 ren_has_dst_i,
    input  logic [REN_W-1:0][ARCH_BITS-1:0]  ren_dst_i,
    input  logic [RET_W-1:0]                 ret_valid_i,
    input  logic [RET_W-1:0][ARCH_BITS-1:0]  ret_arch_i,
    input  logic [RET_W-1:0][PHYS_BITS-1:0]  ret_phys_i,
    output logic                             ren_stall_o,
    output logic [REN_W-1:0][PHYS_BITS-1:0]  ren_psrc1_o,
    output logic [REN_W-1:0][PHYS_BITS-1:0]  ren_psrc2_o,
    output logic [REN_W-1:0][PHYS_BITS-1:0]  ren_pdst_o,
    output logic [REN_W-1:0][PHYS_BITS-1:0]  ren_pold_o
);

    ren_req_t         req       [REN_W];
    ren_rsp_t         rsp       [REN_W];
    ret_upd_t         upd       [RET_W];
    phys_t            slot_tag  [REN_W];
    phys_t            pick      [REN_W];
    logic [REN_W-1:0] pick_ok;
    phys_t            frat_tbl  [ARCH_REGS];
    phys_t            rrat_next [ARCH_REGS];
    pmask_t           freed;
    pmask_t           refd;
    pmask_t           free_mask;
    pmask_t           take;
    logic             accept;
    int               need;
    int               have;

    always_comb begin
        for (int s = 0; s < REN_W; s++) begin
            req[s] = '{valid:   ren_valid_i[s],
                       src1:    ren_src1_i[s],
                       src2:    ren_src2_i[s],
                       has_dst: ren_has_dst_i[s],
                       dst:     ren_dst_i[s]};
        end
        for (int r = 0; r < RET_W; r++) begin
            upd[r] = '{valid: ret_valid_i[r], arch: ret_arch_i[r], phys: ret_phys_i[r]};
        end
    end

    // Hand the k-th free pick to the k-th slot that wants a destination.
    always_comb begin
        need = 0;
        for (int s = 0; s < REN_W; s++) begin
            slot_tag[s] = '0;
            if (ren_valid_i[s] && ren_has_dst_i[s]) begin
                for (int k = 0; k < REN_W; k++) begin
                    if (k == need) slot_tag[s] = pick[k];
                end
                need++;
            end
        end
        have = 0;
        for (int k = 0; k < REN_W; k++) begin
            if (pick_ok[k]) have++;
        end
    end

    assign ren_stall_o = flush_i || (need > have);
    assign accept      = !ren_stall_o;

    always_comb begin
        take = '0;
        for (int s = 0; s < REN_W; s++) begin
            if (accept && ren_valid_i[s] && ren_has_dst_i[s]) take = take | tag_bit(slot_tag[s]);
        end
    end

    rat_front #(.REN_W(REN_W)) u_front (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_i),
        .accept  (accept),
        .req     (req),
        .alloc   (slot_tag),
        .restore (rrat_next),
        .rsp     (rsp),
        .tbl     (frat_tbl)
    );

    rat_retire #(.RET_W(RET_W)) u_retire (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .tbl_next (rrat_next),
        .freed    (freed),
        .refd     (refd)
    );

    free_pool u_pool (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_i),
        .take  (take),
        .give  (freed),
        .keep  (refd),
        .avail (free_mask)
    );

    free_picker #(.REN_W(REN_W)) u_picker (
        .avail   (free_mask),
        .pick    (pick),
        .pick_ok (pick_ok)
    );

    for (genvar s = 0; s < REN_W; s++) begin : g_out
        assign ren_psrc1_o[s] = rsp[s].psrc1;
        assign ren_psrc2_o[s] = rsp[s].psrc2;
        assign ren_pdst_o[s]  = rsp[s].pdst;
        assign ren_pold_o[s]  = rsp[s].pold;
    end

endmodule

// File: rtl/renamer_checker.sv
module renamer_checker
    import renamer_pkg::*;
#(
    parameter int REN_W = REN_WIDTH
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            flush,
    input logic                            stall,
    input logic [REN_W-1:0]                ren_valid,
    input logic [REN_W-1:0]                ren_has_dst,
    input logic [REN_W-1:0][PHYS_BITS-1:0] pdst,
    input phys_t                           frat      [ARCH_REGS],
    input phys_t                           rrat_next [ARCH_REGS],
    input pmask_t                          free_mask
);

    logic [ARCH_REGS*PHYS_BITS-1:0] frat_flat;
    logic [ARCH_REGS*PHYS_BITS-1:0] rnext_flat;
    int                             want;

    always_comb begin
        for (int a = 0; a < ARCH_REGS; a++) begin
            frat_flat[a*PHYS_BITS +: PHYS_BITS]  = frat[a];
            rnext_flat[a*PHYS_BITS +: PHYS_BITS] = rrat_next[a];
        end
        want = 0;
        for (int s = 0; s < REN_W; s++) begin
            if (ren_valid[s] && ren_has_dst[s]) want++;
        end
    end

    for (genvar s = 0; s < REN_W; s++) begin : g_slot
        AST_PDST_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
            (!stall && ren_valid[s] && ren_has_dst[s]) |-> free_mask[pdst[s]]); // R3
    end

    if (REN_W > 1) begin : g_pair
        AST_PDST_DISTINCT: assert property (@(posedge clk) disable iff (rst)
            (!stall && ren_valid[0] && ren_has_dst[0] && ren_valid[1] && ren_has_dst[1])
            |-> (pdst[0] != pdst[1])); // R3
    end

    AST_STALL_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> $stable(frat_flat)); // R5

    AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |-> (want > $countones(free_mask))); // R5

    AST_FLUSH_RESTORES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (frat_flat == $past(rnext_flat))); // R8

    AST_FLUSH_POOL_SIZE: assert property (@(posedge clk) disable iff (rst)
        flush |=> ($countones(free_mask) == PHYS_REGS - ARCH_REGS)); // R8

endmodule

bind dual_rat_renamer renamer_checker #(.REN_W(REN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush_i),
    .stall       (ren_stall_o),
    .ren_valid   (ren_valid_i),
    .ren_has_dst (ren_has_dst_i),
    .pdst        (ren_pdst_o),
    .frat        (frat_tbl),
    .rrat_next   (rrat_next),
    .free_mask   (free_mask)
);

// File: tb/test_dual_rat_renamer.sv
module test_dual_rat_renamer;

    logic             clk;
    logic             rst;
    logic             flush;
    logic [1:0]       ren_valid;
    logic [1:0][2:0]  ren_src1;
    logic [1:0][2:0]  ren_src2;
    logic [1:0]       ren_has_dst;
    logic [1:0][2:0]  ren_dst;
    logic [2:0]       ret_valid;
    logic [2:0][2:0]  ret_arch;
    logic [2:0][6:0]  ret_phys;
    logic             stall;
    logic [1:0][6:0]  psrc1;
    logic [1:0][6:0]  psrc2;
    logic [1:0][6:0]  pdst;
    logic [1:0][6:0]  pold;

    int checks = 0;
    int fails  = 0;

    dual_rat_renamer i_dual_rat_renamer (
        .clk           (clk),
        .rst           (rst),
        .flush_i       (flush),
        .ren_valid_i   (ren_valid),
        .ren_src1_i    (ren_src1),
        .ren_src2_i    (ren_src2),
        .ren_has_dst_i (ren_has_dst),
        .ren_dst_i     (ren_dst),
        .ret_valid_i   (ret_valid),
        .ret_arch_i    (ret_arch),
        .ret_phys_i    (ret_phys),
        .ren_stall_o   (stall),
        .ren_psrc1_o   (psrc1),
        .ren_psrc2_o   (psrc2),
        .ren_pdst_o    (pdst),
        .ren_pold_o    (pold)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Columns: slot0 valid,src1,src2,has_dst,dst | slot1 same |
    // expected slot0 psrc1,psrc2,pdst,pold | slot1 same | stall
    localparam int NV = 5;
    localparam int VEC [NV][19] = '{
        '{1,1,2,1,3, 1,3,0,1,4,  1, 2, 8, 3,   8, 0, 9, 4,  0},
        '{1,3,4,1,5, 1,5,5,1,5,  8, 9,10, 5,  10,10,11,10,  0},
        '{1,5,3,0,0, 1,7,6,1,1, 11, 8, 0, 0,   7, 6,12, 1,  0},
        '{0,0,0,1,2, 1,1,4,1,2,  0, 0, 0, 0,  12, 9,13, 2,  0},
        '{1,2,1,1,0, 1,0,2,0,0, 13,12,14, 0,  14,13, 0, 0,  0}
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        flush       = 1'b0;
        ren_valid   = '0;
        ren_src1    = '0;
        ren_src2    = '0;
        ren_has_dst = '0;
        ren_dst     = '0;
        ret_valid   = '0;
        ret_arch    = '0;
        ret_phys    = '0;
    endtask

    task automatic slot(int s, bit v, int a, int b, bit h, int d);
        ren_valid[s]   = v;
        ren_src1[s]    = 3'(a);
        ren_src2[s]    = 3'(b);
        ren_has_dst[s] = h;
        ren_dst[s]     = 3'(d);
    endtask

    task automatic retire(int r, int a, int p);
        ret_valid[r] = 1'b1;
        ret_arch[r]  = 3'(a);
        ret_phys[r]  = 7'(p);
    endtask

    // Inputs change at the falling edge; outputs are read 5 ns later,
    // well before the rising edge that commits the cycle.
    task automatic settle();
        #5;
    endtask

    task automatic next();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: identity mapping after reset, read through the sources
        for (int i = 0; i < 4; i++) begin
            slot(0, 1, 2*i, 2*i+1, 0, 0);
            slot(1, 1, 2*i+1, 2*i, 0, 0);
            settle();
            chk("R1 reset map slot0", int'(psrc1[0]), 2*i);
            chk("R1 reset map slot1", int'(psrc1[1]), 2*i+1);
            chk("R5 no-dest group never stalls", int'(stall), 0);
            next();
        end

        // R1 R2 R3 R4: vector table, first allocations start at 8
        for (int v = 0; v < NV; v++) begin
            slot(0, VEC[v][0] != 0, VEC[v][1], VEC[v][2], VEC[v][3] != 0, VEC[v][4]);
            slot(1, VEC[v][5] != 0, VEC[v][6], VEC[v][7], VEC[v][8] != 0, VEC[v][9]);
            settle();
            chk("R2 psrc1 slot0", int'(psrc1[0]), VEC[v][10]);
            chk("R2 psrc2 slot0", int'(psrc2[0]), VEC[v][11]);
            chk("R3 pdst slot0",  int'(pdst[0]),  VEC[v][12]);
            chk("R3 pold slot0",  int'(pold[0]),  VEC[v][13]);
            chk("R2 psrc1 slot1", int'(psrc1[1]), VEC[v][14]);
            chk("R2 psrc2 slot1", int'(psrc2[1]), VEC[v][15]);
            chk("R4 pdst slot1",  int'(pdst[1]),  VEC[v][16]);
            chk("R4 pold slot1",  int'(pold[1]),  VEC[v][17]);
            chk("R5 stall",       int'(stall),    VEC[v][18]);
            next();
        end

        // R6 R7: three retirement groups, arch 5 twice in the first
        retire(0, 3, 8); retire(1, 5, 10); retire(2, 5, 11);
        settle(); chk("R6 retire alone no stall", int'(stall), 0); next();
        retire(0, 4, 9); retire(1, 1, 12); retire(2, 2, 13);
        next();
        retire(0, 0, 14);
        next();

        // R6 R9: freed tags come back lowest first (0..5 then 10 then 15)
        slot(0, 1, 6, 7, 1, 6); slot(1, 1, 6, 7, 1, 7);
        settle();
        chk("R6 reuse slot0", int'(pdst[0]), 0);
        chk("R6 reuse slot1", int'(pdst[1]), 1);
        chk("R2 bypass slot1", int'(psrc1[1]), 0);
        chk("R3 pold slot1", int'(pold[1]), 7);
        next();
        slot(0, 1, 6, 7, 1, 6); slot(1, 1, 6, 7, 1, 7);
        settle(); chk("R6 reuse 2", int'(pdst[0]), 2); chk("R6 reuse 3", int'(pdst[1]), 3); next();
        slot(0, 1, 6, 7, 1, 6); slot(1, 1, 6, 7, 1, 7);
        settle(); chk("R6 reuse 4", int'(pdst[0]), 4); chk("R6 reuse 5", int'(pdst[1]), 5); next();
        slot(0, 1, 6, 7, 1, 6); slot(1, 1, 6, 7, 1, 7);
        settle();
        chk("R7 intermediate tag freed", int'(pdst[0]), 10);
        chk("R7 next free after it", int'(pdst[1]), 15);
        next();

        // R8: flush with a same-cycle retirement and a dropped rename
        flush = 1'b1;
        retire(0, 6, 10);
        slot(0, 1, 0, 0, 1, 0);
        settle();
        chk("R8 stall during flush", int'(stall), 1);
        next();
        slot(0, 1, 6, 7, 0, 0);
        slot(1, 1, 0, 5, 1, 1);
        settle();
        chk("R8 restored with same-cycle retire", int'(psrc1[0]), 10);
        chk("R8 restored committed map", int'(psrc2[0]), 7);
        chk("R8 dropped rename left arch 0", int'(psrc1[1]), 14);
        chk("R7 youngest retire kept", int'(psrc2[1]), 11);
        chk("R8 pool rebuilt", int'(pdst[1]), 0);
        chk("R8 pold after flush", int'(pold[1]), 12);
        next();

        // R3: drain the pool down to one register
        for (int n = 0; n < 118; n++) begin
            slot(0, 1, 0, 0, 1, 0);
            settle();
            chk("R3 drain order", int'(pdst[0]), (n < 6) ? n + 1 : n - 6 + 15);
            next();
        end

        // R5: two destinations, one free
        slot(0, 1, 3, 3, 1, 3); slot(1, 1, 3, 3, 1, 3);
        settle(); chk("R5 short pool stalls", int'(stall), 1); next();
        slot(0, 1, 3, 3, 0, 0); slot(1, 1, 3, 0, 1, 2);
        settle();
        chk("R5 stalled group left table", int'(psrc1[0]), 8);
        chk("R5 one dest fits", int'(stall), 0);
        chk("R3 last free tag", int'(pdst[1]), 127);
        chk("R3 pold last", int'(pold[1]), 13);
        chk("R2 src after drain", int'(psrc2[1]), 126);
        next();
        slot(0, 1, 1, 2, 0, 0); slot(1, 1, 3, 4, 0, 0);
        settle(); chk("R5 empty pool no-dest group", int'(stall), 0); next();
        slot(0, 1, 4, 4, 1, 4);
        settle(); chk("R5 empty pool stalls", int'(stall), 1); next();

        // R9: freed tag is not usable in its retirement cycle
        retire(0, 0, 1);
        slot(0, 1, 4, 4, 1, 4);
        settle(); chk("R9 same-cycle free not usable", int'(stall), 1); next();
        slot(0, 1, 4, 4, 1, 4);
        settle();
        chk("R9 next cycle accepted", int'(stall), 0);
        chk("R6 displaced committed tag reused", int'(pdst[0]), 14);
        chk("R3 pold of arch 4", int'(pold[0]), 9);
        next();

        // R1: reset again restores identity and the first free tag
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        slot(0, 1, 4, 6, 1, 6);
        settle();
        chk("R1 map after second reset", int'(psrc1[0]), 4);
        chk("R1 first free after reset", int'(pdst[0]), 8);
        next();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule